// File: doc/BRIEF.md
# Register-Port Open-Bus Data Latch

This block sits between a host processor and the eight memory-mapped registers of a graphics controller. It models the 8-bit data latch on the register side of the host bus. That latch is charge-held in real silicon. It keeps whatever value last crossed the bus. Host accesses are decoded in the window 0x2000 to 0x3FFF. Only the low three address bits pick a register, so the eight registers repeat every 8 bytes across the window.

Every write to a register reloads the latch, including a write to a register that can only be read. A read returns the register's own data on the bits that register drives, and the latch contents on every other bit. Fully write-only registers therefore read back stale bus contents instead of zero. The status register drives only its upper bits, so its low five bits always come from the latch. After a read, the driven bits are stored into the latch and the undriven bits keep their old values.

An optional timeout models charge decay. It clears the latch after a set number of clocks with no register access, and it is off by default. A small controller with two states tracks this. `LS_DISCHARGED` is the state after reset and after a timeout; here the latch is zero. `LS_HOLDING` is entered on any register access. The controller moves from `LS_DISCHARGED` to `LS_HOLDING` on an access. It moves from `LS_HOLDING` back to `LS_DISCHARGED` when the idle count expires, and that move clears the latch.

Top module: `regbus_openbus_latch`

## Requirements
- R1: After reset the latch holds 0x00, so a read of a write-only register returns 0x00.
- R2: An access with address bits 15:13 equal to 3'b001 selects register address[2:0], and pulses exactly one bit of `reg_wr_en` or `reg_rd_en`: the bit at that index.
- R3: An access outside 0x2000–0x3FFF raises no strobe, leaves the latch unchanged and gives `host_rdata` = 0x00.
- R4: A write to any register, including the read-only status register at index 2, loads `host_wdata` into the latch on that clock edge.
- R5: A read of a write-only register (indices 0, 1, 3, 5, 6) returns the latch unchanged, whatever drive mask is presented, and does not alter the latch.
- R6: A read of the status register (index 2) takes bits 7:5 from register data where the drive mask is set, and always takes bits 4:0 from the latch.
- R7: A read of index 4 or 7 returns register data on bits whose drive mask is 1, and latch contents on bits whose mask is 0.
- R8: After a read, the latch holds the bits the register actually drove; every undriven bit keeps its previous value.
- R9: When read and write strobes are both high on an in-window access, the access is a write: only `reg_wr_en` pulses and the latch takes `host_wdata`.
- R10: With `DECAY_CYCLES` = N > 0, the latch becomes 0x00 after N consecutive clock edges with no in-window access; an access before that restarts the count.
- R11: With `DECAY_CYCLES` = 0 (the default), the latch holds its value indefinitely while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| reg_rdata | input | 64 | Read data of each register, index i in bits 8i+7:8i |
| reg_drive_mask | input | 64 | Bits each register drives on a read, same packing |
| host_rdata | output | 8 | Read data returned to the host (0x00 when not reading) |
| reg_wr_en | output | 8 | One-hot write strobe to the register logic |
| reg_rd_en | output | 8 | One-hot read strobe to the register logic |

## Verification
The bench writes through every register index and reads back through every index at mirrored addresses, with varied data and drive masks. A design that zeroed undriven bits would fail the write-only and status reads. A design that decoded more than three address bits would miss the mirrors. A design that stored a whole read word would corrupt the follow-up readback of the latch. Other checks cover accesses just outside the window, simultaneous read and write, and a write to the read-only status register. The decay count is tested against an instance with a short timeout, one edge either side of expiry, so an off-by-one count or a count that fails to restart on access shows up as a wrong readback.

// File: rtl/obl_pkg.sv
package obl_pkg;

    // Charge state of the open-bus latch.
    typedef enum logic {
        LS_DISCHARGED = 1'b0,
        LS_HOLDING    = 1'b1
    } hold_state_t;

endpackage

// File: rtl/obl_decode.sv
module obl_decode #(
    parameter int AW       = 16,
    parameter int IDX_W    = 3,
    parameter int WIN_LSB  = 13,
    parameter logic [AW-1:0] WIN_BASE = 16'h2000,
    localparam int NREG    = 1 << IDX_W
) (
    input  logic [AW-1:0]    host_addr,
    input  logic             host_rd,
    input  logic             host_wr,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             acc_wr,
    output logic             acc_rd,
    output logic [NREG-1:0]  wr_en,
    output logic [NREG-1:0]  rd_en
);

    logic unused_mid;
    assign unused_mid = ^host_addr[WIN_LSB-1:IDX_W];

    assign hit    = (host_addr[AW-1:WIN_LSB] == WIN_BASE[AW-1:WIN_LSB]);
    assign idx    = host_addr[IDX_W-1:0];
    assign acc_wr = hit && host_wr;
    assign acc_rd = hit && host_rd && !host_wr;

    for (genvar i = 0; i < NREG; i++) begin : g_strobe
        assign wr_en[i] = acc_wr && (idx == IDX_W'(i));
        assign rd_en[i] = acc_rd && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/obl_merge.sv
module obl_merge #(
    parameter int DW              = 8,
    parameter int IDX_W           = 3,
    parameter int STATUS_IDX      = 2,
    parameter int STATUS_DRV_BITS = 3,
    localparam int NREG           = 1 << IDX_W,
    parameter logic [NREG-1:0] WO_MAP = 8'b0110_1011
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [NREG*DW-1:0] reg_rdata,
    input  logic [NREG*DW-1:0] reg_drive_mask,
    input  logic [DW-1:0]      latch_q,
    output logic [DW-1:0]      eff_mask,
    output logic [DW-1:0]      sel_data,
    output logic [DW-1:0]      merged
);

    localparam logic [DW-1:0] LOW_ONES  = DW'((1 << (DW - STATUS_DRV_BITS)) - 1);
    localparam logic [DW-1:0] STAT_CAP  = ~LOW_ONES;

    logic [DW-1:0] cap_mask [NREG];
    logic [DW-1:0] data_arr [NREG];

    // Per-register limit on which bits may ever be driven.
    for (genvar i = 0; i < NREG; i++) begin : g_cap
        localparam logic [DW-1:0] CAPV =
            WO_MAP[i]         ? '0 :
            (i == STATUS_IDX) ? STAT_CAP : '1;
        assign cap_mask[i] = reg_drive_mask[i*DW +: DW] & CAPV;
        assign data_arr[i] = reg_rdata[i*DW +: DW];
    end

    always_comb begin
        eff_mask = cap_mask[idx];
        sel_data = data_arr[idx];
        merged   = (sel_data & eff_mask) | (latch_q & ~eff_mask);
    end

endmodule

// File: rtl/obl_hold.sv
module obl_hold
    import obl_pkg::*;
#(
    parameter int DW           = 8,
    parameter int DECAY_CYCLES = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] rd_mask,
    output logic [DW-1:0] latch_q
);

    hold_state_t state, state_nx;
    logic        acc;
    logic        timeout;

    assign acc = acc_wr || acc_rd;

    if (DECAY_CYCLES > 0) begin : g_decay
        localparam int CW = (DECAY_CYCLES > 1) ? $clog2(DECAY_CYCLES) : 1;
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (acc || state != LS_HOLDING)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
        assign timeout = (state == LS_HOLDING) && !acc &&
                         (cnt == CW'(DECAY_CYCLES - 1));
    end else begin : g_nodecay
        assign timeout = 1'b0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LS_DISCHARGED;
        else        state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            LS_DISCHARGED: if (acc)     state_nx = LS_HOLDING;
            LS_HOLDING:    if (timeout) state_nx = LS_DISCHARGED;
            default:       state_nx = LS_DISCHARGED;
        endcase
    end

    // Latch contents.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (acc_wr)
            latch_q <= wdata;
        else if (acc_rd)
            latch_q <= (latch_q & ~rd_mask) | (rd_data & rd_mask);
        else if (timeout)
            latch_q <= '0;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> latch_q == $past(wdata));                                   // R4
    AST_READ_KEEPS_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> (latch_q & ~$past(rd_mask)) == ($past(latch_q) & ~$past(rd_mask))); // R8
    AST_DISCHARGED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_DISCHARGED) |-> latch_q == '0);                           // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && state == LS_HOLDING && !timeout) |=> $stable(latch_q));        // R11

endmodule

// File: rtl/regbus_openbus_latch.sv
module regbus_openbus_latch #(
    parameter int AW              = 16,
    parameter int DW              = 8,
    parameter int IDX_W           = 3,
    parameter int WIN_LSB         = 13,
    parameter logic [AW-1:0] WIN_BASE = 16'h2000,
    parameter int STATUS_IDX      = 2,
    parameter int STATUS_DRV_BITS = 3,
    parameter int DECAY_CYCLES    = 0,
    localparam int NREG           = 1 << IDX_W,
    parameter logic [NREG-1:0] WO_MAP = 8'b0110_1011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DW-1:0]      host_wdata,
    input  logic [NREG*DW-1:0] reg_rdata,
    input  logic [NREG*DW-1:0] reg_drive_mask,
    output logic [DW-1:0]      host_rdata,
    output logic [NREG-1:0]    reg_wr_en,
    output logic [NREG-1:0]    reg_rd_en
);

    localparam int LOW_BITS = DW - STATUS_DRV_BITS;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             acc_wr, acc_rd;
    logic [DW-1:0]    latch_q, eff_mask, sel_data, merged;

    obl_decode #(
        .AW(AW), .IDX_W(IDX_W), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .hit(hit), .idx(idx), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en)
    );

    obl_merge #(
        .DW(DW), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX),
        .STATUS_DRV_BITS(STATUS_DRV_BITS), .WO_MAP(WO_MAP)
    ) u_merge (
        .idx(idx), .reg_rdata(reg_rdata), .reg_drive_mask(reg_drive_mask),
        .latch_q(latch_q), .eff_mask(eff_mask), .sel_data(sel_data),
        .merged(merged)
    );

    obl_hold #(
        .DW(DW), .DECAY_CYCLES(DECAY_CYCLES)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .wdata(host_wdata), .rd_data(sel_data), .rd_mask(eff_mask),
        .latch_q(latch_q)
    );

    assign host_rdata = acc_rd ? merged : '0;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en}));                                     // R2
    AST_NO_STROBE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[AW-1:WIN_LSB] != WIN_BASE[AW-1:WIN_LSB]) |->
        (reg_wr_en == '0 && reg_rd_en == '0 && host_rdata == '0));             // R3
    AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en == '0 && reg_rd_en == '0 && DECAY_CYCLES == 0) |=> $stable(latch_q)); // R3
    AST_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en[STATUS_IDX] |->
        host_rdata[LOW_BITS-1:0] == latch_q[LOW_BITS-1:0]);                    // R6
    AST_WO_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(reg_rd_en & WO_MAP)) |-> (host_rdata == latch_q) ##1 $stable(latch_q)); // R5
    AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && host_rd && host_wr) |-> (reg_rd_en == '0 && reg_wr_en != '0));  // R9

endmodule

// File: tb/regbus_openbus_latch_test.sv
module regbus_openbus_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [63:0] rdata_flat = '0;
    logic [63:0] mask_flat = '0;
    logic [7:0]  rdata, rdata_dk;
    logic [7:0]  wr_en, rd_en, wr_en_dk, rd_en_dk;

    int checks = 0;
    int fails = 0;
    logic [7:0] mdl = 8'h00;

    always #10 clk = ~clk;

    regbus_openbus_latch uut (
        .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_rd(rd), .host_wr(wr),
        .host_wdata(wdata), .reg_rdata(rdata_flat), .reg_drive_mask(mask_flat),
        .host_rdata(rdata), .reg_wr_en(wr_en), .reg_rd_en(rd_en)
    );

    regbus_openbus_latch #(.DECAY_CYCLES(4)) uut_dk (
        .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_rd(rd), .host_wr(wr),
        .host_wdata(wdata), .reg_rdata(rdata_flat), .reg_drive_mask(mask_flat),
        .host_rdata(rdata_dk), .reg_wr_en(wr_en_dk), .reg_rd_en(rd_en_dk)
    );

    function automatic logic [7:0] cap(int i);
        if (i == 0 || i == 1 || i == 3 || i == 5 || i == 6) return 8'h00;
        if (i == 2) return 8'hE0;
        return 8'hFF;
    endfunction

    function automatic logic in_win(logic [15:0] a);
        return a[15:13] == 3'b001;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(logic [15:0] a, logic [7:0] d, logic both);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = both;
        #5;
        check("R2", wr_en, in_win(a) ? 8'(1 << a[2:0]) : 8'h00);
        check(both ? "R9" : "R3", rd_en, 8'h00);
        @(posedge clk);
        if (in_win(a)) mdl = d;
        #1 wr = 1'b0; rd = 1'b0;
    endtask

    task automatic host_read(string req, logic [15:0] a, logic [7:0] rv, logic [7:0] mk);
        logic [7:0] eff, exp;
        @(negedge clk);
        addr = a; rd = 1'b1; wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rdata_flat[i*8 +: 8] = rv;
            mask_flat[i*8 +: 8]  = mk;
        end
        eff = mk & cap(int'(a[2:0]));
        exp = in_win(a) ? ((rv & eff) | (mdl & ~eff)) : 8'h00;
        #5;
        check(req, rdata, exp);
        check("R2", rd_en, in_win(a) ? 8'(1 << a[2:0]) : 8'h00);
        @(posedge clk);
        if (in_win(a)) mdl = (rv & eff) | (mdl & ~eff);
        #1 rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset value visible through write-only and status low bits
        host_read("R1", 16'h2005, 8'hFF, 8'hFF);
        host_read("R1", 16'h2002, 8'h00, 8'h00);

        // Exhaustive write-index x read-index sweep at mirrored addresses
        for (int w = 0; w < 8; w++) begin
            for (int r = 0; r < 8; r++) begin
                logic [15:0] aw, ar;
                logic [7:0] d, rv, mk;
                string tag;
                aw = 16'h2000 + 16'(w) + 16'(8 * (w * 37 + r));
                ar = 16'h3FF8 - 16'(8 * (r * 11 + w)) + 16'(r);
                d  = 8'(w * 73 + r * 29 + 5);
                rv = 8'(r * 51 + w * 17) ^ 8'hA5;
                mk = 8'(w * 45 + r * 99 + 3);
                host_write(aw, d, 1'b0);        // R4 (includes index 2)
                host_read("R4", 16'h2000, 8'h3C, 8'hFF);
                if (cap(r) == 8'h00) tag = "R5";
                else if (r == 2)     tag = "R6";
                else                 tag = "R7";
                host_read(tag, ar, rv, mk);
                host_read("R8", 16'h2006, 8'h99, 8'hFF);
            end
        end

        // R3: outside window has no effect
        host_write(16'h2001, 8'hC3, 1'b0);
        host_write(16'h1FFF, 8'h11, 1'b0);
        host_write(16'h4000, 8'h22, 1'b0);
        host_read("R3", 16'hC002, 8'hFF, 8'hFF);
        host_read("R3", 16'h1FFC, 8'hFF, 8'hFF);
        host_read("R3", 16'h2003, 8'h00, 8'h00);

        // R9: read and write together is a write
        host_write(16'h2004, 8'h6E, 1'b1);
        host_read("R9", 16'h2001, 8'h00, 8'h00);

        // R10 / R11: decay on the short-timeout instance only
        host_write(16'h2000, 8'h5A, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk); addr = 16'h2003; rd = 1'b1; #5;
        check("R10", rdata_dk, 8'h5A);
        check("R11", rdata, 8'h5A);
        @(posedge clk); #1 rd = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); addr = 16'h2006; rd = 1'b1; #5;
        check("R10", rdata_dk, 8'h00);
        check("R11", rdata, 8'h5A);
        @(posedge clk); #1 rd = 1'b0;
        repeat (60) @(posedge clk);
        host_read("R11", 16'h3FFD, 8'h00, 8'hFF);

        finish_run();
    end

endmodule